// File: doc/BRIEF.md
# Candy Vending Sequencer

This block is the control state machine of a candy dispenser that sells one item for 75 cents. A separate datapath adds up the inserted coins, compares the running total with the price and reports the result as three flags (total below, equal to, or above the price), together with a flag that says whether change can be paid out. The sequencer takes a one-cycle coin pulse and a one-cycle return-request pulse from the coin mechanism. From these and the datapath flags it produces four Moore-decoded command strobes: dispense the item, pay change, refund every coin, and clear the running total.

After a coin pulse the sequencer spends one cycle in an evaluation state, so the datapath has time to update the total before its flags are used. An exact total dispenses at once. An overpayment pays change and then dispenses when change can be given. When change cannot be given, or when the user asks for the money back, all coins are refunded. Each strobe lasts exactly one clock, and the machine then goes back to idle. A parameter selects binary or one-hot state storage.

Top module: `vend_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) puts the sequencer in idle with all four strobes low, including when it is applied in the middle of a sale.
- R2: In idle with `coin_i` and `ret_i` both low, the sequencer stays in idle and all strobes stay low, whatever the comparison flags are.
- R3: A coin pulse seen in idle moves the sequencer to the evaluation state at that edge. All strobes are low during the evaluation cycle.
- R4: In evaluation with only `lt_i` set, the sequencer returns to idle with no strobe.
- R5: In evaluation with only `eq_i` set, the next cycle drives `release_candy` and `clear_sum` high for exactly one cycle, followed by idle.
- R6: In evaluation with only `gt_i` set and `chg_ok_i` high, the next cycle drives `return_change` alone for one cycle, the cycle after that drives `release_candy` and `clear_sum` for one cycle, and then the sequencer is idle.
- R7: In evaluation with only `gt_i` set and `chg_ok_i` low, the next cycle drives `return_all_coins` and `clear_sum` for exactly one cycle, followed by idle.
- R8: A return pulse seen in idle (with `coin_i` low) drives `return_all_coins` and `clear_sum` in the next cycle for exactly one cycle.
- R9: Coin and return pulses that arrive outside idle are ignored: they change neither the strobe sequence in progress nor the state reached afterwards.
- R10: At most one of `release_candy`, `return_change` and `return_all_coins` is high in any cycle, and `clear_sum` is high only together with `release_candy` or `return_all_coins`.
- R11: In evaluation, a flag set with no bit set or more than one bit set among `lt_i`, `eq_i` and `gt_i` sends the sequencer back to idle with no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| coin_i | input | 1 | One-cycle pulse: a valid coin was inserted |
| ret_i | input | 1 | One-cycle pulse: the user asks for the coins back |
| lt_i | input | 1 | Accumulated total is below the price |
| eq_i | input | 1 | Accumulated total equals the price |
| gt_i | input | 1 | Accumulated total is above the price |
| chg_ok_i | input | 1 | The datapath can pay out change |
| release_candy | output | 1 | Dispense one item |
| return_change | output | 1 | Pay out the excess over the price |
| return_all_coins | output | 1 | Refund the whole accumulated total |
| clear_sum | output | 1 | Reset the datapath total to zero |

## Verification
The assertions assume that the coin mechanism never raises `coin_i` and `ret_i` in the same cycle. An input-side property states this, and every directed scenario drives at most one of the two pulses at a time. The properties that follow the strobe sequence after evaluation assume exactly one comparison flag. The stimulus sets the flags before the coin pulse and holds them stable through the evaluation cycle. Only the scenario that covers R11 gives a malformed flag set on purpose.

// File: rtl/vend_pkg.sv
package vend_pkg;
   localparam int unsigned NUM_ST = 5;
   localparam int unsigned ST_W   = $clog2(NUM_ST);

   typedef enum logic [ST_W-1:0] {
      ST_IDLE   = 3'd0,
      ST_EVAL   = 3'd1,
      ST_SELL   = 3'd2,
      ST_CHANGE = 3'd3,
      ST_REFUND = 3'd4
   } vend_st_e;

   typedef struct packed {
      logic give_item;
      logic give_change;
      logic give_back;
      logic zero_total;
   } vend_cmd_t;
endpackage

// File: rtl/vend_step.sv
module vend_step
   import vend_pkg::*;
(
   input  vend_st_e cur_i,
   input  logic     coin_i,
   input  logic     ret_i,
   input  logic     lt_i,
   input  logic     eq_i,
   input  logic     gt_i,
   input  logic     chg_ok_i,
   output vend_st_e nxt_o
);
   logic [2:0] cmp_flags;
   logic       cmp_valid;

   assign cmp_flags = {lt_i, eq_i, gt_i};
   assign cmp_valid = (cmp_flags == 3'b100) || (cmp_flags == 3'b010) || (cmp_flags == 3'b001);

   always_comb begin
      nxt_o = ST_IDLE;
      unique case (cur_i)
         ST_IDLE: begin
            if (coin_i)     nxt_o = ST_EVAL;
            else if (ret_i) nxt_o = ST_REFUND;
            else            nxt_o = ST_IDLE;
         end
         ST_EVAL: begin
            if (!cmp_valid)    nxt_o = ST_IDLE;
            else if (eq_i)     nxt_o = ST_SELL;
            else if (gt_i)     nxt_o = chg_ok_i ? ST_CHANGE : ST_REFUND;
            else               nxt_o = ST_IDLE;
         end
         ST_CHANGE: nxt_o = ST_SELL;
         ST_SELL:   nxt_o = ST_IDLE;
         ST_REFUND: nxt_o = ST_IDLE;
         default:   nxt_o = ST_IDLE;
      endcase
   end
endmodule

// File: rtl/vend_state_reg.sv
module vend_state_reg
   import vend_pkg::*;
#(
   parameter int unsigned ONE_HOT = 0
) (
   input  logic     clk,
   input  logic     rst,
   input  vend_st_e nxt_i,
   output vend_st_e cur_o
);
   generate
      if (ONE_HOT > 1) begin : g_bad_enc
         $error("vend_state_reg: ONE_HOT must be 0 or 1");
      end

      if (ONE_HOT == 1) begin : g_hot
         logic [NUM_ST-1:0] hot_q;
         logic [NUM_ST-1:0] hot_d;

         always_comb begin
            hot_d        = '0;
            hot_d[nxt_i] = 1'b1;
         end

         always_ff @(posedge clk) begin
            if (rst) hot_q <= NUM_ST'(1) << ST_IDLE;
            else     hot_q <= hot_d;
         end

         always_comb begin
            cur_o = ST_IDLE;
            for (int k = 0; k < NUM_ST; k++) begin
               if (hot_q[k]) cur_o = vend_st_e'(ST_W'(k));
            end
         end

         assert_state_onehot_R1: assert property (@(posedge clk) disable iff (rst)
            $onehot(hot_q));
      end else begin : g_bin
         vend_st_e st_q;

         always_ff @(posedge clk) begin
            if (rst) st_q <= ST_IDLE;
            else     st_q <= nxt_i;
         end

         assign cur_o = st_q;

         assert_state_legal_R1: assert property (@(posedge clk) disable iff (rst)
            (int'(st_q) < NUM_ST));
      end
   endgenerate
endmodule

// File: rtl/vend_decode.sv
module vend_decode
   import vend_pkg::*;
(
   input  vend_st_e  cur_i,
   output vend_cmd_t cmd_o
);
   always_comb begin
      cmd_o = '0;
      unique case (cur_i)
         ST_SELL:   begin cmd_o.give_item = 1'b1; cmd_o.zero_total = 1'b1; end
         ST_CHANGE: cmd_o.give_change = 1'b1;
         ST_REFUND: begin cmd_o.give_back = 1'b1; cmd_o.zero_total = 1'b1; end
         default:   cmd_o = '0;
      endcase
   end
endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
   import vend_pkg::*;
#(
   parameter int unsigned ONE_HOT = 0
) (
   input  logic clk,
   input  logic rst,
   input  logic coin_i,
   input  logic ret_i,
   input  logic lt_i,
   input  logic eq_i,
   input  logic gt_i,
   input  logic chg_ok_i,
   output logic release_candy,
   output logic return_change,
   output logic return_all_coins,
   output logic clear_sum
);
   vend_st_e  cur_st;
   vend_st_e  nxt_st;
   vend_cmd_t cmd;

   vend_step u_step (
      .cur_i    (cur_st),
      .coin_i   (coin_i),
      .ret_i    (ret_i),
      .lt_i     (lt_i),
      .eq_i     (eq_i),
      .gt_i     (gt_i),
      .chg_ok_i (chg_ok_i),
      .nxt_o    (nxt_st)
   );

   vend_state_reg #(.ONE_HOT(ONE_HOT)) u_reg (
      .clk   (clk),
      .rst   (rst),
      .nxt_i (nxt_st),
      .cur_o (cur_st)
   );

   vend_decode u_dec (
      .cur_i (cur_st),
      .cmd_o (cmd)
   );

   assign release_candy    = cmd.give_item;
   assign return_change    = cmd.give_change;
   assign return_all_coins = cmd.give_back;
   assign clear_sum        = cmd.zero_total;

   // input-side premise used by R8 and R9
   assert_inputs_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
      !(coin_i && ret_i));

   assert_reset_quiet_R1: assert property (@(posedge clk)
      rst |=> !(release_candy || return_change || return_all_coins || clear_sum));

   assert_coin_to_eval_R3: assert property (@(posedge clk) disable iff (rst)
      (cur_st == ST_IDLE && coin_i)
         |=> (cur_st == ST_EVAL) && !(release_candy || return_change || return_all_coins || clear_sum));

   assert_exact_sells_R5: assert property (@(posedge clk) disable iff (rst)
      (cur_st == ST_EVAL && eq_i && !lt_i && !gt_i) |=> (release_candy && clear_sum));

   assert_item_one_cycle_R5: assert property (@(posedge clk) disable iff (rst)
      release_candy |=> (!release_candy && cur_st == ST_IDLE));

   assert_change_then_item_R6: assert property (@(posedge clk) disable iff (rst)
      return_change |=> (release_candy && clear_sum && !return_change));

   assert_refund_one_cycle_R7: assert property (@(posedge clk) disable iff (rst)
      return_all_coins |=> (!return_all_coins && cur_st == ST_IDLE));

   assert_return_refunds_R8: assert property (@(posedge clk) disable iff (rst)
      (cur_st == ST_IDLE && ret_i && !coin_i) |=> (return_all_coins && clear_sum));

   assert_one_action_R10: assert property (@(posedge clk) disable iff (rst)
      $onehot0({release_candy, return_change, return_all_coins})
      && (!clear_sum || release_candy || return_all_coins));

   assert_bad_flags_idle_R11: assert property (@(posedge clk) disable iff (rst)
      (cur_st == ST_EVAL && $countones({lt_i, eq_i, gt_i}) != 1) |=> (cur_st == ST_IDLE));
endmodule

// File: tb/test_vend_ctrl.sv
module test_vend_ctrl;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic coin_i = 1'b0, ret_i = 1'b0;
   logic lt_i = 1'b0, eq_i = 1'b0, gt_i = 1'b0, chg_ok_i = 1'b0;
   logic release_candy, return_change, return_all_coins, clear_sum;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   vend_ctrl i_vend_ctrl (
      .clk(clk), .rst(rst), .coin_i(coin_i), .ret_i(ret_i),
      .lt_i(lt_i), .eq_i(eq_i), .gt_i(gt_i), .chg_ok_i(chg_ok_i),
      .release_candy(release_candy), .return_change(return_change),
      .return_all_coins(return_all_coins), .clear_sum(clear_sum)
   );

   // strobe vector {item, change, refund, clear}
   function automatic logic [3:0] outs();
      return {release_candy, return_change, return_all_coins, clear_sum};
   endfunction

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [3:0] exp);
      logic [3:0] got;
      got = outs();
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got=%b expected=%b at %0t", req, got, exp, $time);
      end
      checks++;
      if ((got[3] + got[2] + got[1]) > 1 || (got[0] && !got[3] && !got[1])) begin
         errors++;
         $display("FAIL R10 got=%b expected=exclusive strobes at %0t", got, $time);
      end
   endtask

   task automatic flags(input logic l, input logic e, input logic g, input logic c);
      lt_i = l; eq_i = e; gt_i = g; chg_ok_i = c;
   endtask

   task automatic coin_pulse();
      coin_i = 1'b1;
      tick();
      coin_i = 1'b0;
   endtask

   task automatic t_reset();
      tick(); tick();
      chk("R1 in reset", 4'b0000);
      rst = 1'b0;
      tick();
      chk("R1 after reset", 4'b0000);
      // reset applied mid-sale
      flags(0, 1, 0, 0);
      coin_pulse();
      rst = 1'b1;
      tick();
      rst = 1'b0;
      chk("R1 mid-sale reset", 4'b0000);
      tick();
      chk("R1 idle after reset", 4'b0000);
   endtask

   task automatic t_idle_hold();
      flags(0, 1, 0, 1);
      for (int i = 0; i < 4; i++) begin
         tick();
         chk("R2 idle hold eq", 4'b0000);
      end
      flags(0, 0, 1, 1);
      tick();
      chk("R2 idle hold gt", 4'b0000);
   endtask

   task automatic t_below();
      flags(1, 0, 0, 0);
      coin_pulse();
      chk("R3 eval quiet", 4'b0000);
      tick();
      chk("R4 below price", 4'b0000);
      flags(0, 1, 0, 0);
      tick();
      chk("R4 back in idle", 4'b0000);
   endtask

   task automatic t_exact();
      flags(0, 1, 0, 0);
      coin_pulse();
      chk("R3 eval quiet", 4'b0000);
      tick();
      chk("R5 dispense", 4'b1001);
      tick();
      chk("R5 one cycle", 4'b0000);
   endtask

   task automatic t_over_change();
      flags(0, 0, 1, 1);
      coin_pulse();
      chk("R3 eval quiet", 4'b0000);
      tick();
      chk("R6 change", 4'b0100);
      tick();
      chk("R6 dispense", 4'b1001);
      tick();
      chk("R6 idle", 4'b0000);
   endtask

   task automatic t_over_nochange();
      flags(0, 0, 1, 0);
      coin_pulse();
      tick();
      chk("R7 refund", 4'b0011);
      tick();
      chk("R7 one cycle", 4'b0000);
   endtask

   task automatic t_return();
      flags(1, 0, 0, 0);
      ret_i = 1'b1;
      tick();
      ret_i = 1'b0;
      chk("R8 refund", 4'b0011);
      tick();
      chk("R8 one cycle", 4'b0000);
   endtask

   task automatic t_ignore();
      flags(0, 1, 0, 0);
      coin_pulse();
      ret_i = 1'b1;         // return during eval
      tick();
      ret_i = 1'b0;
      chk("R9 return ignored in eval", 4'b1001);
      coin_i = 1'b1;        // coin during dispense
      tick();
      coin_i = 1'b0;
      chk("R9 coin ignored in sell", 4'b0000);
      tick();
      chk("R9 still idle", 4'b0000);
      flags(0, 0, 1, 1);
      coin_pulse();
      tick();
      chk("R9 change", 4'b0100);
      ret_i = 1'b1;         // return during change
      tick();
      ret_i = 1'b0;
      chk("R9 return ignored in change", 4'b1001);
      tick();
      chk("R9 idle", 4'b0000);
   endtask

   task automatic t_bad_flags();
      flags(0, 0, 0, 1);
      coin_pulse();
      tick();
      chk("R11 no flag", 4'b0000);
      flags(0, 1, 1, 1);
      coin_pulse();
      tick();
      chk("R11 two flags", 4'b0000);
      tick();
      chk("R11 idle", 4'b0000);
   endtask

   bit done = 1'b0;

   initial begin
      #(200000 * 4);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_idle_hold();
      t_below();
      t_exact();
      t_over_change();
      t_over_nochange();
      t_return();
      t_ignore();
      t_bad_flags();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule